// File: doc/BRIEF.md
# Memory management abort status register

This block holds the control and status word that a memory management unit keeps for its most recent access fault. Software sets one bit of it, the relocation enable, which leaves the block on its own output so that the address translation path can act on it. The rest of the word is status. When the fault logic reports an abort, the block records three things about the failing access. The first is which of the three fault kinds occurred. The second is the privilege mode the access ran in. The third is whether it went to instruction or data space, and which of the eight pages it addressed.

The first abort after the status is armed fills the status fields and then freezes them. Software reads the word from the register bus at its fixed I/O-page address, octal 17777572, to learn why the fault happened. Any later write to the register re-arms the status. Software learns in this way the first fault of a burst, not the last. Deciding when a fault occurs and raising the trap are done elsewhere. This block only receives the abort event and its attributes.

Top module: `mmu_abort_status`

## Requirements
- R1: Reset clears the whole word, so that a read returns 0x0000 and `reloc_en` is 0, and arms the status for capture.
- R2: A bus write to the register address (bus_sel=1, bus_wr=1) loads bit 0, the relocation enable driven on `reloc_en`, from bus_wdata[0]. It leaves every other bit as it was and re-arms the status. A write to any other address changes nothing.
- R3: A bus read (bus_sel=1, bus_wr=0) at address octal 17777572 returns the word. Bits 12 to 7 of that word always read 0. When bus_sel is 0, or the address differs, bus_rdata is 0.
- R4: An abort (abt_valid=1) while armed latches a set of fields and freezes them. Bit 15 takes the read-only violation flag, bit 14 the page length error and bit 13 the non-resident flag. Bits 6:5 take the mode (00 kernel, 01 supervisor, 11 user) and bits 3:1 take the page. Further aborts are ignored until the next write to the register.
- R5: An abort in the illegal mode code 10 records 10 in bits 6:5 and sets bit 15, whatever the read-only violation input is.
- R6: Bit 4 records 1 only for a data-space access whose mode has data space enabled. The enable bits are dspace_en[0] for user, [1] for supervisor and [2] for kernel. The illegal mode and every instruction-space access record 0.
- R7: A write and an armed abort in the same cycle both take effect. Bit 0 takes the written value, and the status fields capture the abort and stay frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register bus cycle active |
| bus_wr | input | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_addr | input | ADDR_W | Physical address of the bus cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when the cycle does not address this register |
| abt_valid | input | 1 | An access abort is reported this cycle |
| abt_ro | input | 1 | Abort cause: write to a read-only page |
| abt_len | input | 1 | Abort cause: page length error |
| abt_nonres | input | 1 | Abort cause: non-resident page |
| abt_mode | input | 2 | Mode of the failing access (00 kernel, 01 supervisor, 10 illegal, 11 user) |
| abt_dspace | input | 1 | Failing access went to data space |
| dspace_en | input | 3 | Data space enables: [0] user, [1] supervisor, [2] kernel |
| abt_page | input | 3 | Page number of the failing access |
| reloc_en | output | 1 | Relocation enable bit |

## Verification
The assertions take the abort attributes as meaningful only in a cycle where abt_valid is high. They also expect the bus to present a single read or write per cycle with bus_wr steady while bus_sel is high. The stimulus changes the inputs only at the falling clock edge and pulses abt_valid for exactly one cycle. It drops the abort attributes to zero between events, so a stale attribute can never be mistaken for a capture. Reads are issued only in cycles with no abort and no write, so a read always sees the settled word.

// File: rtl/mmu_abort_status.sv
module mmu_abort_status #(
  parameter int ADDR_W = 22,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(22'o17777572)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              abt_valid,
  input  logic              abt_ro,
  input  logic              abt_len,
  input  logic              abt_nonres,
  input  logic [1:0]        abt_mode,
  input  logic              abt_dspace,
  input  logic [2:0]        dspace_en,
  input  logic [2:0]        abt_page,
  output logic              reloc_en
);

  localparam logic [1:0] MODE_KERN = 2'b00;
  localparam logic [1:0] MODE_SUPV = 2'b01;
  localparam logic [1:0] MODE_BAD  = 2'b10;
  localparam logic [1:0] MODE_USER = 2'b11;

  logic       hit, wr_hit, take, mode_den;
  logic [2:0] flags_q;
  logic [1:0] mode_q;
  logic       space_q;
  logic [2:0] page_q;
  logic       reloc_q;
  logic       frozen_q;
  logic       unused_wbits;

  assign hit    = bus_sel && (bus_addr == REG_ADDR);
  assign wr_hit = hit && bus_wr;
  assign take   = abt_valid && !frozen_q;
  assign unused_wbits = &{1'b0, bus_wdata[15:1]};

  always_comb begin
    case (abt_mode)
      MODE_KERN: mode_den = dspace_en[2];
      MODE_SUPV: mode_den = dspace_en[1];
      MODE_USER: mode_den = dspace_en[0];
      default:   mode_den = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q  <= '0;
      mode_q   <= MODE_KERN;
      space_q  <= 1'b0;
      page_q   <= '0;
      reloc_q  <= 1'b0;
      frozen_q <= 1'b0;
    end else begin
      if (wr_hit) reloc_q <= bus_wdata[0];
      if (take) begin
        flags_q  <= {abt_ro || (abt_mode == MODE_BAD), abt_len, abt_nonres};
        mode_q   <= abt_mode;
        space_q  <= abt_dspace && mode_den;
        page_q   <= abt_page;
        frozen_q <= 1'b1;
      end else if (wr_hit) begin
        frozen_q <= 1'b0;
      end
    end
  end

  assign reloc_en  = reloc_q;
  assign bus_rdata = (hit && !bus_wr)
                   ? {flags_q, 6'b0, mode_q, space_q, page_q, reloc_q}
                   : 16'h0000;

  a_r4_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |=> $stable({flags_q, mode_q, space_q, page_q}));

  a_r4_capture_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> frozen_q && page_q == $past(abt_page));

  a_r5_illegal_ro: assert property (@(posedge clk) disable iff (!rst_n)
    take && abt_mode == MODE_BAD |=> flags_q[2] && !space_q);

  a_r6_ispace_zero: assert property (@(posedge clk) disable iff (!rst_n)
    take && !abt_dspace |=> !space_q);

  a_r2_reloc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(reloc_en));

  a_r7_both_apply: assert property (@(posedge clk) disable iff (!rst_n)
    take && wr_hit |=> frozen_q && reloc_en == $past(bus_wdata[0]));

  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> bus_rdata == 16'h0000);

endmodule

// File: tb/sim_mmu_abort_status.sv
module sim_mmu_abort_status;
  localparam int ADDR_W = 22;
  localparam logic [ADDR_W-1:0] RADDR = 22'o17777572;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic abt_valid = 0, abt_ro = 0, abt_len = 0, abt_nonres = 0, abt_dspace = 0;
  logic [1:0] abt_mode = '0;
  logic [2:0] dspace_en = '0, abt_page = '0;
  logic reloc_en;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mmu_abort_status #(.ADDR_W(ADDR_W), .REG_ADDR(RADDR)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .abt_valid(abt_valid), .abt_ro(abt_ro), .abt_len(abt_len),
    .abt_nonres(abt_nonres), .abt_mode(abt_mode), .abt_dspace(abt_dspace),
    .dspace_en(dspace_en), .abt_page(abt_page), .reloc_en(reloc_en));

  // {kind(1=abort), wdata, ro len nr, mode, dsp, den, page, expected word}
  localparam int NV = 12;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 16'hFFFF, 3'b000, 2'b00, 1'b0, 3'b000, 3'd0, 16'h0001}, // R2
    {1'b1, 16'h0000, 3'b010, 2'b01, 1'b1, 3'b010, 3'd5, 16'h403B}, // R4 R6
    {1'b1, 16'h0000, 3'b100, 2'b11, 1'b1, 3'b111, 3'd7, 16'h403B}, // R4 frozen
    {1'b0, 16'h0000, 3'b000, 2'b00, 1'b0, 3'b000, 3'd0, 16'h403A}, // R2
    {1'b1, 16'h0000, 3'b001, 2'b10, 1'b1, 3'b111, 3'd2, 16'hA044}, // R5 R6
    {1'b0, 16'h0001, 3'b000, 2'b00, 1'b0, 3'b000, 3'd0, 16'hA045}, // R2
    {1'b1, 16'h0000, 3'b100, 2'b11, 1'b1, 3'b110, 3'd0, 16'h8061}, // R6 user off
    {1'b0, 16'h0001, 3'b000, 2'b00, 1'b0, 3'b000, 3'd0, 16'h8061}, // R2
    {1'b1, 16'h0000, 3'b011, 2'b00, 1'b1, 3'b100, 3'd3, 16'h6017}, // R4 R6 kernel
    {1'b0, 16'h0001, 3'b000, 2'b00, 1'b0, 3'b000, 3'd0, 16'h6017}, // R2
    {1'b1, 16'h0000, 3'b000, 2'b00, 1'b0, 3'b111, 3'd6, 16'h000D}, // R6 I space
    {1'b0, 16'h0000, 3'b000, 2'b00, 1'b0, 3'b000, 3'd0, 16'h000C}  // R2
  };

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(output logic [15:0] v, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_addr = '0;
  endtask

  task automatic drive(input logic do_wr, input logic [ADDR_W-1:0] a,
                       input logic [15:0] wd, input logic do_abt,
                       input logic [2:0] fl, input logic [1:0] md,
                       input logic dsp, input logic [2:0] den, input logic [2:0] pg);
    @(negedge clk);
    bus_sel = do_wr; bus_wr = do_wr; bus_addr = a; bus_wdata = wd;
    abt_valid = do_abt; {abt_ro, abt_len, abt_nonres} = fl;
    abt_mode = md; abt_dspace = dsp; dspace_en = den; abt_page = pg;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    abt_valid = 0; {abt_ro, abt_len, abt_nonres} = 3'b000;
    abt_mode = 2'b00; abt_dspace = 0; dspace_en = '0; abt_page = '0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(v, RADDR);
    chk(v, 16'h0000, "R1 reset word");
    chk({15'b0, reloc_en}, 16'h0000, "R1 reset reloc_en");

    for (int i = 0; i < NV; i++) begin
      logic [44:0] e;
      e = VEC[i];
      drive(!e[44], RADDR, e[43:28], e[44], e[27:25], e[24:23], e[22], e[21:19], e[18:16]);
      rd(v, RADDR);
      chk(v, e[15:0], $sformatf("R4 vector %0d", i));
    end

    rd(v, RADDR ^ 22'd2);
    chk(v, 16'h0000, "R3 other address reads zero");
    @(negedge clk);
    #1 chk(bus_rdata, 16'h0000, "R3 idle bus reads zero");

    drive(1'b1, RADDR, 16'h0001, 1'b1, 3'b010, 2'b01, 1'b0, 3'b000, 3'd1);
    rd(v, RADDR);
    chk(v, 16'h4023, "R7 write with abort");
    drive(1'b0, RADDR, 16'h0000, 1'b1, 3'b101, 2'b11, 1'b1, 3'b111, 3'd4);
    rd(v, RADDR);
    chk(v, 16'h4023, "R7 status frozen after joint cycle");

    drive(1'b1, RADDR ^ 22'o100, 16'h0000, 1'b0, 3'b000, 2'b00, 1'b0, 3'b000, 3'd0);
    rd(v, RADDR);
    chk(v, 16'h4023, "R2 write to other address ignored");
    chk({15'b0, reloc_en}, 16'h0001, "R2 reloc_en output");

    drive(1'b1, RADDR, 16'hFFFE, 1'b0, 3'b000, 2'b00, 1'b0, 3'b000, 3'd0);
    rd(v, RADDR);
    chk(v, 16'h4022, "R3 unused bits read zero after all-ones write");
    drive(1'b0, RADDR, 16'h0000, 1'b1, 3'b000, 2'b11, 1'b1, 3'b001, 3'd7);
    rd(v, RADDR);
    chk(v, 16'h007E, "R6 user data space enabled");

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(v, RADDR);
    chk(v, 16'h0000, "R1 reset clears captured word");
    drive(1'b0, RADDR, 16'h0000, 1'b1, 3'b001, 2'b01, 1'b1, 3'b010, 3'd3);
    rd(v, RADDR);
    chk(v, 16'h2036, "R1 armed after reset");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule